// File: doc/BRIEF.md
# External Bus Access Cycle Sequencer

This block paces single accesses to an external memory bus and drives the control strobes for each one. The strobes are a chip select per region, an address latch enable, a read enable, a write enable, and a byte-enable/command-latch line. A requester hands over one access at a time through a valid/ready handshake. Each access names a region (0 to 3) and a direction. The sequencer counts functional-clock cycles from the start of the access and opens each strobe inside a window that is programmed for that region. When the region's cycle length runs out, it closes every strobe, whatever that strobe's own close time is.

Every region has its own settings. These are a read cycle length and a write cycle length, a doubling bit for both lengths, a window for each strobe, and a rule for gaps between accesses. A new access may be accepted in the last cycle of the current one. It then starts in the very next cycle, so a strobe that is open at the end and opens at count zero in the new access stays open with no glitch. Otherwise a gap of idle cycles is inserted. The gap is enabled separately for a successor in the same region and for a successor in another region, and its length comes from the region that just finished.

Top module: `xbus_cycle_seq`

## Requirements
- R1: While reset is low, all cs_n bits are 1, oe_n and we_n are 1, ale and be_cle are 0, done is 0 and req_ready is 1.
- R2: An accepted access occupies L consecutive cycles, starting in the cycle after acceptance. L is the region's read length (cfg_rd_cyc) or write length (cfg_wr_cyc), each 5 bits at bit offset region*5. A programmed length of 0 gives L = 1. done is 1 only in the last of the L cycles.
- R3: When cfg_gran[region] is 1, the selected length is doubled before use.
- R4: Strobe s is active in access cycle k when on <= k < off. The window fields are 5 bits at bit offset (region*5+s)*5, with s = 0 chip select, 1 ale, 2 read enable, 3 write enable, 4 be_cle. The read enable opens only on reads (req_write = 0) and the write enable only on writes.
- R5: After the last cycle of an access with no successor, every strobe is inactive, even when its close time lies past L.
- R6: req_ready is 1 when the block is idle or in the last cycle of an access, and 0 otherwise, including during a gap.
- R7: When a successor is accepted with no gap, its first cycle follows the last cycle at once. A strobe that is active in the last cycle and has open time 0 in the successor stays active with no inactive cycle between.
- R8: When the successor targets the same region and cfg_gap_same[cur] is 1, all strobes are held inactive for cfg_gap_dly[cur] cycles before the successor starts. Here cur is the finishing region, and the delay field is 4 bits at offset cur*4.
- R9: When the successor targets a different region, the gap is governed by cfg_gap_diff[cur] instead of cfg_gap_same[cur].
- R10: A gap delay of 0 inserts no idle cycles, even when the gap is enabled.
- R11: In idle cycles and gap cycles, ale and be_cle are low, and cs_n, oe_n and we_n are high.
- R12: At most one cs_n bit is low at any time, and it is the bit of the access's region.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Request accepted on this edge if valid |
| req_region | input | 2 | Target region of the request |
| req_write | input | 1 | 1 = write access, 0 = read access |
| cfg_rd_cyc | input | 20 | Read cycle length per region, 5 bits each |
| cfg_wr_cyc | input | 20 | Write cycle length per region, 5 bits each |
| cfg_gran | input | 4 | Length doubling bit per region |
| cfg_on | input | 100 | Strobe open times, 5 bits per region and strobe |
| cfg_off | input | 100 | Strobe close times, 5 bits per region and strobe |
| cfg_gap_same | input | 4 | Gap enable for a same-region successor |
| cfg_gap_diff | input | 4 | Gap enable for a different-region successor |
| cfg_gap_dly | input | 16 | Gap length per region, 4 bits each |
| cs_n | output | 4 | Chip selects, active low |
| ale | output | 1 | Address latch enable, active high |
| oe_n | output | 1 | Read enable, active low |
| we_n | output | 1 | Write enable, active low |
| be_cle | output | 1 | Byte enable / command latch, active high |
| done | output | 1 | Last cycle of the current access |

## Verification
The bench walks a table of single accesses across all regions and both directions. It compares every strobe in every cycle against a window model, so a design that counts from the wrong cycle, ignores the doubling bit, or treats a zero length as zero cycles shows up in both the strobe pattern and the timing of done. A read window that closes past the cycle length exposes a design that lets strobes outlive the access. Pipelined pairs measure the cycles from one done to the next. This catches a gap that was picked from the wrong enable, taken from the successor's region, or inserted for a zero delay. It also checks that no strobe leaks out during a gap. A back-to-back write pair with windows open from count zero catches a design that briefly releases the write and byte-enable strobes at the boundary.

// File: rtl/xbs_pkg.sv
package xbs_pkg;
  localparam int NSTB   = 5;
  localparam int SB_CS  = 0;
  localparam int SB_ALE = 1;
  localparam int SB_OE  = 2;
  localparam int SB_WE  = 3;
  localparam int SB_BE  = 4;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACC  = 2'd1,
    ST_GAP  = 2'd2
  } seq_st_e;
endpackage

// File: rtl/xbs_len_sel.sv
// Picks cycle length and gap settings for the region currently in flight.
module xbs_len_sel #(
  parameter int NCS = 4,
  parameter int TW  = 5,
  parameter int GW  = 4,
  localparam int RW = $clog2(NCS),
  localparam int CW = TW + 1
) (
  input  logic [RW-1:0]     sel,
  input  logic              wr,
  input  logic [NCS*TW-1:0] cfg_rd_cyc,
  input  logic [NCS*TW-1:0] cfg_wr_cyc,
  input  logic [NCS-1:0]    cfg_gran,
  input  logic [NCS-1:0]    cfg_gap_same,
  input  logic [NCS-1:0]    cfg_gap_diff,
  input  logic [NCS*GW-1:0] cfg_gap_dly,
  output logic [CW-1:0]     len,
  output logic              gap_same,
  output logic              gap_diff,
  output logic [GW-1:0]     gap_dly
);
  logic [TW-1:0] raw;
  logic [CW-1:0] scaled;

  always_comb begin
    raw    = wr ? cfg_wr_cyc[int'(sel)*TW +: TW] : cfg_rd_cyc[int'(sel)*TW +: TW];
    scaled = cfg_gran[sel] ? {raw, 1'b0} : {1'b0, raw};
    len    = (scaled == '0) ? CW'(1) : scaled;
  end

  assign gap_same = cfg_gap_same[sel];
  assign gap_diff = cfg_gap_diff[sel];
  assign gap_dly  = cfg_gap_dly[int'(sel)*GW +: GW];
endmodule

// File: rtl/xbs_time_sel.sv
// Extracts per-strobe open/close times of one region.
module xbs_time_sel
  import xbs_pkg::*;
#(
  parameter int NCS = 4,
  parameter int TW  = 5,
  localparam int RW = $clog2(NCS)
) (
  input  logic [RW-1:0]           sel,
  input  logic [NCS*NSTB*TW-1:0]  cfg_on,
  input  logic [NCS*NSTB*TW-1:0]  cfg_off,
  output logic [NSTB-1:0][TW-1:0] on_t,
  output logic [NSTB-1:0][TW-1:0] off_t
);
  for (genvar s = 0; s < NSTB; s++) begin : g_fld
    assign on_t[s]  = cfg_on [(int'(sel)*NSTB + s)*TW +: TW];
    assign off_t[s] = cfg_off[(int'(sel)*NSTB + s)*TW +: TW];
  end
endmodule

// File: rtl/xbs_strobe_dec.sv
// Window compare per strobe; direction qualifies the read and write enables.
module xbs_strobe_dec
  import xbs_pkg::*;
#(
  parameter int TW = 5,
  localparam int CW = TW + 1
) (
  input  logic                    en,
  input  logic                    wr,
  input  logic [CW-1:0]           cnt,
  input  logic [NSTB-1:0][TW-1:0] on_t,
  input  logic [NSTB-1:0][TW-1:0] off_t,
  output logic [NSTB-1:0]         act
);
  for (genvar s = 0; s < NSTB; s++) begin : g_win
    logic win;
    assign win = en && (cnt >= CW'(on_t[s])) && (cnt < CW'(off_t[s]));
    if (s == SB_OE) begin : g_rd
      assign act[s] = win && !wr;
    end else if (s == SB_WE) begin : g_wr
      assign act[s] = win && wr;
    end else begin : g_any
      assign act[s] = win;
    end
  end
endmodule

// File: rtl/xbus_cycle_seq.sv
module xbus_cycle_seq
  import xbs_pkg::*;
#(
  parameter int NCS = 4,
  parameter int TW  = 5,
  parameter int GW  = 4,
  localparam int RW = $clog2(NCS),
  localparam int CW = TW + 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [RW-1:0]          req_region,
  input  logic                   req_write,
  input  logic [NCS*TW-1:0]      cfg_rd_cyc,
  input  logic [NCS*TW-1:0]      cfg_wr_cyc,
  input  logic [NCS-1:0]         cfg_gran,
  input  logic [NCS*NSTB*TW-1:0] cfg_on,
  input  logic [NCS*NSTB*TW-1:0] cfg_off,
  input  logic [NCS-1:0]         cfg_gap_same,
  input  logic [NCS-1:0]         cfg_gap_diff,
  input  logic [NCS*GW-1:0]      cfg_gap_dly,
  output logic [NCS-1:0]         cs_n,
  output logic                   ale,
  output logic                   oe_n,
  output logic                   we_n,
  output logic                   be_cle,
  output logic                   done
);
  seq_st_e       st_q, st_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic [GW-1:0] gcnt_q, gcnt_n;
  logic [RW-1:0] cur_reg_q, cur_reg_n, pend_reg_q, pend_reg_n;
  logic          cur_wr_q, cur_wr_n, pend_wr_q, pend_wr_n;
  logic [NSTB-1:0] act_q, act_n;

  logic [CW-1:0] cur_len;
  logic          c_gap_same, c_gap_diff;
  logic [GW-1:0] c_gap_dly;
  logic [NSTB-1:0][TW-1:0] n_on, n_off;
  logic          accept, gap_need;

  // Settings of the region in flight: length and gap rule.
  xbs_len_sel #(.NCS(NCS), .TW(TW), .GW(GW)) u_len (
    .sel(cur_reg_q), .wr(cur_wr_q),
    .cfg_rd_cyc(cfg_rd_cyc), .cfg_wr_cyc(cfg_wr_cyc), .cfg_gran(cfg_gran),
    .cfg_gap_same(cfg_gap_same), .cfg_gap_diff(cfg_gap_diff), .cfg_gap_dly(cfg_gap_dly),
    .len(cur_len), .gap_same(c_gap_same), .gap_diff(c_gap_diff), .gap_dly(c_gap_dly)
  );

  // Strobe windows of the region that the next cycle belongs to.
  xbs_time_sel #(.NCS(NCS), .TW(TW)) u_time (
    .sel(cur_reg_n), .cfg_on(cfg_on), .cfg_off(cfg_off),
    .on_t(n_on), .off_t(n_off)
  );

  xbs_strobe_dec #(.TW(TW)) u_dec (
    .en(st_n == ST_ACC), .wr(cur_wr_n), .cnt(cnt_n),
    .on_t(n_on), .off_t(n_off), .act(act_n)
  );

  assign done      = (st_q == ST_ACC) && (cnt_q == cur_len - 1'b1);
  assign req_ready = (st_q == ST_IDLE) || done;
  assign accept    = req_valid && req_ready;
  assign gap_need  = ((req_region == cur_reg_q) ? c_gap_same : c_gap_diff)
                     && (c_gap_dly != '0);

  always_comb begin
    st_n       = st_q;
    cnt_n      = cnt_q;
    gcnt_n     = gcnt_q;
    cur_reg_n  = cur_reg_q;
    cur_wr_n   = cur_wr_q;
    pend_reg_n = pend_reg_q;
    pend_wr_n  = pend_wr_q;
    unique case (st_q)
      ST_IDLE: begin
        if (accept) begin
          st_n      = ST_ACC;
          cnt_n     = '0;
          cur_reg_n = req_region;
          cur_wr_n  = req_write;
        end
      end
      ST_ACC: begin
        if (!done) begin
          cnt_n = cnt_q + 1'b1;
        end else if (accept && !gap_need) begin
          cnt_n     = '0;
          cur_reg_n = req_region;
          cur_wr_n  = req_write;
        end else if (accept) begin
          st_n       = ST_GAP;
          gcnt_n     = c_gap_dly - 1'b1;
          pend_reg_n = req_region;
          pend_wr_n  = req_write;
        end else begin
          st_n = ST_IDLE;
        end
      end
      ST_GAP: begin
        if (gcnt_q == '0) begin
          st_n      = ST_ACC;
          cnt_n     = '0;
          cur_reg_n = pend_reg_q;
          cur_wr_n  = pend_wr_q;
        end else begin
          gcnt_n = gcnt_q - 1'b1;
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      cnt_q      <= '0;
      gcnt_q     <= '0;
      cur_reg_q  <= '0;
      cur_wr_q   <= 1'b0;
      pend_reg_q <= '0;
      pend_wr_q  <= 1'b0;
      act_q      <= '0;
    end else begin
      st_q       <= st_n;
      cnt_q      <= cnt_n;
      gcnt_q     <= gcnt_n;
      cur_reg_q  <= cur_reg_n;
      cur_wr_q   <= cur_wr_n;
      pend_reg_q <= pend_reg_n;
      pend_wr_q  <= pend_wr_n;
      act_q      <= act_n;
    end
  end

  for (genvar r = 0; r < NCS; r++) begin : g_cs
    assign cs_n[r] = ~(act_q[SB_CS] && (cur_reg_q == RW'(r)));
  end
  assign ale    = act_q[SB_ALE];
  assign oe_n   = ~act_q[SB_OE];
  assign we_n   = ~act_q[SB_WE];
  assign be_cle = act_q[SB_BE];

  // R12: never two chip selects at once
  p_cs_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));

  // R4: read and write enables are never open together
  p_rdwr_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(!oe_n && !we_n));

  // R2: cycle counter never passes the programmed length
  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ACC) |-> (cnt_q < cur_len));

  // R8, R11: gap cycles show only idle levels
  p_gap_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_GAP) |-> (&cs_n && oe_n && we_n && !ale && !be_cle));

  // R5: with no successor, every strobe is released after the last cycle
  p_end_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !req_valid) |=> (&cs_n && oe_n && we_n && !ale && !be_cle));

  // R6: no acceptance inside an access before its last cycle
  p_ready_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q != ST_IDLE) && !done) |-> !req_ready);
endmodule

// File: tb/sim_xbus_cycle_seq.sv
`timescale 1ns/1ps
module sim_xbus_cycle_seq;
  localparam int NCS = 4;
  localparam int TW  = 5;
  localparam int GW  = 4;
  localparam int NS  = 5;

  localparam int RD [4] = '{4, 3, 0, 6};
  localparam int WR [4] = '{5, 3, 2, 6};
  localparam int GR [4] = '{0, 1, 0, 0};
  localparam int ON  [4][5] = '{'{0,0,1,1,0}, '{0,1,2,2,0}, '{0,0,0,0,0}, '{2,2,3,3,2}};
  localparam int OFF [4][5] = '{'{4,1,4,5,5}, '{6,2,9,5,6}, '{1,1,1,2,2}, '{6,3,6,6,6}};
  localparam int GS [4] = '{1, 1, 0, 0};
  localparam int GD [4] = '{0, 0, 0, 1};
  localparam int GL [4] = '{3, 0, 0, 2};

  // {region[1:0], write, expected length[5:0]}
  localparam logic [8:0] VEC [8] = '{
    {2'd0, 1'b0, 6'd4}, {2'd0, 1'b1, 6'd5}, {2'd1, 1'b0, 6'd6}, {2'd1, 1'b1, 6'd6},
    {2'd2, 1'b0, 6'd1}, {2'd2, 1'b1, 6'd2}, {2'd3, 1'b0, 6'd6}, {2'd3, 1'b1, 6'd6}};

  localparam logic [7:0] IDLE_PINS = 8'b1111_0110;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_ready, req_write;
  logic [1:0] req_region;
  logic [NCS*TW-1:0] cfg_rd_cyc, cfg_wr_cyc;
  logic [NCS-1:0] cfg_gran, cfg_gap_same, cfg_gap_diff;
  logic [NCS*NS*TW-1:0] cfg_on, cfg_off;
  logic [NCS*GW-1:0] cfg_gap_dly;
  logic [NCS-1:0] cs_n;
  logic ale, oe_n, we_n, be_cle, done;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  xbus_cycle_seq #(.NCS(NCS), .TW(TW), .GW(GW)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_region(req_region), .req_write(req_write),
    .cfg_rd_cyc(cfg_rd_cyc), .cfg_wr_cyc(cfg_wr_cyc), .cfg_gran(cfg_gran),
    .cfg_on(cfg_on), .cfg_off(cfg_off), .cfg_gap_same(cfg_gap_same),
    .cfg_gap_diff(cfg_gap_diff), .cfg_gap_dly(cfg_gap_dly),
    .cs_n(cs_n), .ale(ale), .oe_n(oe_n), .we_n(we_n), .be_cle(be_cle), .done(done));

  function automatic logic [7:0] pins();
    return {cs_n, ale, oe_n, we_n, be_cle};
  endfunction

  function automatic logic [7:0] exp_pins(int r, int w, int k);
    logic [3:0] c = 4'hF;
    logic [4:0] win;
    for (int s = 0; s < NS; s++) win[s] = (k >= ON[r][s]) && (k < OFF[r][s]);
    if (win[0]) c[r] = 1'b0;
    return {c, win[1], !(w == 0 && win[2]), !(w == 1 && win[3]), win[4]};
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // One access from idle; compares every cycle against the window model.
  task automatic single(input int r, input int w, input int len);
    int k;
    req_valid = 1'b1; req_region = 2'(r); req_write = w[0];
    chk(req_ready == 1'b1, "R6 idle ready", int'(req_ready), 1);
    @(negedge clk);
    req_valid = 1'b0;
    k = 0;
    forever begin
      chk(pins() == exp_pins(r, w, k), "R4 R12 strobes", int'(pins()), int'(exp_pins(r, w, k)));
      chk(req_ready == (k == len - 1), "R6 ready in access", int'(req_ready), int'(k == len - 1));
      if (done || k > 40) break;
      k++;
      @(negedge clk);
    end
    chk(k + 1 == len, "R2 R3 access length", k + 1, len);
    @(negedge clk);
    chk(pins() == IDLE_PINS, "R5 R11 release after end", int'(pins()), int'(IDLE_PINS));
  endtask

  // Pipelined pair; returns cycles from first done to second done.
  task automatic pipe(input int ra, input int wa, input int rb, input int wb,
                      input int quiet_n, output int cnt, output bit quiet);
    req_valid = 1'b1; req_region = 2'(ra); req_write = wa[0];
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_region = 2'(rb); req_write = wb[0];
    while (!done) @(negedge clk);
    cnt = 0; quiet = 1'b1;
    do begin
      @(negedge clk);
      cnt++;
      if (cnt == 1) req_valid = 1'b0;
      if (cnt <= quiet_n && pins() != IDLE_PINS) quiet = 1'b0;
    end while (!done && cnt < 60);
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int n;
    bit q;
    for (int r = 0; r < NCS; r++) begin
      cfg_rd_cyc[r*TW +: TW] = TW'(RD[r]);
      cfg_wr_cyc[r*TW +: TW] = TW'(WR[r]);
      cfg_gran[r]     = GR[r][0];
      cfg_gap_same[r] = GS[r][0];
      cfg_gap_diff[r] = GD[r][0];
      cfg_gap_dly[r*GW +: GW] = GW'(GL[r]);
      for (int s = 0; s < NS; s++) begin
        cfg_on [(r*NS + s)*TW +: TW] = TW'(ON[r][s]);
        cfg_off[(r*NS + s)*TW +: TW] = TW'(OFF[r][s]);
      end
    end
    rst_n = 1'b0; req_valid = 1'b0; req_region = '0; req_write = 1'b0;
    repeat (3) @(negedge clk);
    chk(pins() == IDLE_PINS, "R1 reset strobes", int'(pins()), int'(IDLE_PINS));
    chk(done == 1'b0, "R1 reset done", int'(done), 0);
    chk(req_ready == 1'b1, "R1 reset ready", int'(req_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 8; i++) begin
      single(int'(VEC[i][8:7]), int'(VEC[i][6]), int'(VEC[i][5:0]));
      @(negedge clk);
    end

    // R8 R11: same region, gap enabled with delay 3
    pipe(0, 0, 0, 0, 3, n, q);
    chk(n == 7, "R8 same-region gap spacing", n, 7);
    chk(q, "R8 R11 gap cycles idle", int'(q), 1);
    // R9: different region uses the different-region enable of the finisher
    pipe(3, 0, 0, 0, 2, n, q);
    chk(n == 6, "R9 diff-region gap spacing", n, 6);
    chk(q, "R9 R11 gap cycles idle", int'(q), 1);
    pipe(3, 0, 3, 0, 0, n, q);
    chk(n == 6, "R9 same region ignores diff enable", n, 6);
    pipe(0, 0, 1, 0, 0, n, q);
    chk(n == 6, "R9 diff enable off gives no gap", n, 6);
    // R10: enabled gap with zero delay
    pipe(1, 0, 1, 1, 0, n, q);
    chk(n == 6, "R10 zero delay no gap", n, 6);

    // R7: back-to-back writes, write and byte enables stay asserted
    req_valid = 1'b1; req_region = 2'd2; req_write = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    chk(!we_n && be_cle, "R7 first access k0", int'({we_n, be_cle}), 1);
    @(negedge clk);
    chk(done && !we_n, "R7 first access last", int'({done, we_n}), 2);
    @(negedge clk);
    req_valid = 1'b0;
    chk(!we_n && be_cle && !done, "R7 no glitch at boundary", int'({done, we_n, be_cle}), 1);
    @(negedge clk);
    chk(done == 1'b1, "R7 second access end", int'(done), 1);
    @(negedge clk);
    chk(pins() == IDLE_PINS, "R5 R11 idle after merge", int'(pins()), int'(IDLE_PINS));

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule